// File: doc/BRIEF.md
# Processor Bus Chip-Select and Acknowledge Logic

This block sits between an asynchronous-bus microprocessor and an 8-bit register and memory bus. It supports two bus personalities. In the decoded personality it turns the top three address bits into selects for the block's own registers, RAM, ROM and a spare peripheral. It returns a transfer acknowledge, which for the spare peripheral is delayed by a programmable number of wait states. For interrupt-acknowledge cycles it asserts a valid-peripheral-address output so that the processor takes an autovector.

In the external-select personality a microcontroller supplies its own chip selects. The block then passes the RAM select through, gated by reset, and takes its register select from an external input. In this personality the two shared pins become inputs. The personality and a clock-source choice are read from two strap pins a fixed number of clocks after reset is released.

During the first few bus cycles after start-up in the decoded personality, the RAM region is served by the ROM so that the processor can boot. A memory output enable is produced from the read/write line for every strobed read.

Top module: `cpu_bus_glue`

## Requirements
- R1: The straps are captured on the STRAP_DELAY-th rising clock edge (default 4) after reset is released. `strap_i[0]`=1 selects the external-select personality and 0 selects the decoded one. `strap_i[1]` is copied to `clk_src_sel`. Until capture, `straps_valid` is 0 and every select, `oe_n`, `dtack_n` and `vpa_n` stays inactive. After capture, the captured values stay fixed until the next reset.
- R2: In the decoded personality, with `as_n` low, region codes on `addr_hi` map as follows: 3'b000 gives RAM (`ram_cs_n` low), 3'b001 gives ROM (`rom_cs_n` low), 3'b010 gives the register select (`reg_sel` high, with `reg_offset` equal to `addr_lo`; otherwise `reg_offset` is 0), and 3'b110 gives the spare select (`spare_cs_n` low). The codes 3'b011, 3'b100 and 3'b101 drive no select.
- R3: In the decoded personality, region 3'b111 with `as_n` low drives `vpa_n` low and keeps `dtack_n` high.
- R4: In the decoded personality, every region except 3'b110 and 3'b111 drives `dtack_n` low in the same cycle that `as_n` goes low (zero wait states).
- R5: For region 3'b110, `dtack_n` goes low only after 2^c rising edges have been seen with `as_n` low, where c is the 2-bit wait code. Code 3 (8 waits) is the value after reset. A new code is loaded on a clock edge with `wait_we` high.
- R6: In the decoded personality, the first BOOT_CYCLES strobe cycles after capture (default 4) are boot cycles. A strobe cycle ends on the clock edge where `as_n` is seen high after being low. During boot cycles, region 3'b000 asserts `rom_cs_n` and keeps `ram_cs_n` high.
- R7: `oe_n` is low exactly while the straps are valid, `as_n` is low and `rw_n` is high.
- R8: When `as_n` is high, `rom_cs_n`, `spare_cs_n`, `oe_n`, `dtack_n` and `vpa_n` are high and `reg_sel` is low. In the decoded personality `ram_cs_n` is also high.
- R9: In the external-select personality, `ram_cs_n` follows `ext_ram_cs_n` regardless of `as_n`, and `reg_sel` is `!ext_reg_cs_n` qualified by `as_n` low. `rom_cs_n`, `vpa_n` and `dtack_n` stay high, and both pin drive enables are 0. The spare select still decodes region 3'b110.
- R10: `ram_cs_n` is high whenever `rst_n` is low, in both personalities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Strap levels on the two data pins |
| addr_hi | input | 3 | Region bits of the address |
| addr_lo | input | 8 | Register offset bits of the address |
| as_n | input | 1 | Address strobe, active low |
| rw_n | input | 1 | High for read, low for write |
| ext_ram_cs_n | input | 1 | External RAM select (external-select personality) |
| ext_reg_cs_n | input | 1 | External register select (external-select personality) |
| wait_we | input | 1 | Load enable for the spare wait code |
| wait_code | input | 2 | Spare wait code c, giving 2^c waits |
| straps_valid | output | 1 | Straps have been captured |
| bus_mode | output | 1 | 1 for the external-select personality |
| clk_src_sel | output | 1 | Captured clock-source strap |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| spare_cs_n | output | 1 | Spare select, active low |
| reg_sel | output | 1 | Register-file select |
| reg_offset | output | 8 | Register offset while selected |
| oe_n | output | 1 | Memory output enable, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| vpa_n | output | 1 | Valid peripheral address, active low |
| romcs_pin_drive | output | 1 | Shared RAM/ROM select pin is driven as an output |
| vpa_pin_drive | output | 1 | Shared select/VPA pin is driven as an output |

## Verification
The assertions check on every cycle the following properties. Strobe-idle outputs are inactive. The autovector and the acknowledge never coexist. A spare access never acknowledges on its first cycle. RAM is never selected during reset or in a boot cycle. The external-select personality keeps its decoded-only outputs quiet. The captured personality stays fixed. The bench scenarios are needed to show the exact wait-state count for each code, the length of the boot window and the capture edge of the straps. They also show that the region map routes each code to the right select and that the external selects pass through.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

   localparam logic [2:0] RGN_RAM     = 3'b000;
   localparam logic [2:0] RGN_ROM     = 3'b001;
   localparam logic [2:0] RGN_REGS    = 3'b010;
   localparam logic [2:0] RGN_SPARE   = 3'b110;
   localparam logic [2:0] RGN_AUTOVEC = 3'b111;

   typedef enum logic {
      BUS_DECODED = 1'b0,
      BUS_EXTSEL  = 1'b1
   } bus_mode_t;

   typedef struct packed {
      logic ram;
      logic rom;
      logic regs;
      logic spare;
      logic autovec;
      logic zero_wait;
   } region_sel_t;

endpackage

// File: rtl/cbg_strap_sampler.sv
module cbg_strap_sampler #(
   parameter int STRAP_DELAY = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         strap_i,
   output logic               valid,
   output cbg_pkg::bus_mode_t mode,
   output logic               clk_src
);
   import cbg_pkg::*;

   localparam int CW = $clog2(STRAP_DELAY + 1);

   generate
      if (STRAP_DELAY < 1 || STRAP_DELAY > 8) begin : g_bad_delay
         $error("STRAP_DELAY must lie in 1..8");
      end
   endgenerate

   logic [CW-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         valid    <= 1'b0;
         mode     <= BUS_DECODED;
         clk_src  <= 1'b0;
      end else if (!valid) begin
         edge_cnt <= edge_cnt + 1'b1;
         if (edge_cnt == CW'(STRAP_DELAY - 1)) begin
            valid   <= 1'b1;
            mode    <= bus_mode_t'(strap_i[0]);
            clk_src <= strap_i[1];
         end
      end
   end

   p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> (valid && $stable(mode) && $stable(clk_src)));

endmodule

// File: rtl/cbg_region_dec.sv
module cbg_region_dec #(
   parameter bit BOOT_REMAP = 1'b1
) (
   input  logic [2:0]           region,
   input  logic                 boot,
   output cbg_pkg::region_sel_t sel
);
   import cbg_pkg::*;

   logic in_ram;
   assign in_ram = (region == RGN_RAM);

   generate
      if (BOOT_REMAP) begin : g_remap
         always_comb begin
            sel.ram = in_ram && !boot;
            sel.rom = (region == RGN_ROM) || (in_ram && boot);
         end
      end else begin : g_flat
         always_comb begin
            sel.ram = in_ram;
            sel.rom = (region == RGN_ROM);
         end
      end
   endgenerate

   always_comb begin
      sel.regs      = (region == RGN_REGS);
      sel.spare     = (region == RGN_SPARE);
      sel.autovec   = (region == RGN_AUTOVEC);
      sel.zero_wait = (region != RGN_SPARE) && (region != RGN_AUTOVEC);
   end

   always_comb begin
      assert (!(sel.ram && sel.rom)) else $error("p_mem_excl_r6 failed");
   end

endmodule

// File: rtl/cbg_ack_gen.sv
module cbg_ack_gen #(
   parameter int WAIT_CODE_W = 2,
   parameter int RESET_CODE  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enable,
   input  logic                   as_n,
   input  logic                   zero_wait,
   input  logic                   spare,
   input  logic                   wait_we,
   input  logic [WAIT_CODE_W-1:0] wait_code,
   output logic                   dtack_n
);
   localparam int MAX_CODE = (1 << WAIT_CODE_W) - 1;
   localparam int MAX_WAIT = 1 << MAX_CODE;
   localparam int CW       = $clog2(MAX_WAIT + 1);

   generate
      if (WAIT_CODE_W < 1 || WAIT_CODE_W > 3) begin : g_bad_w
         $error("WAIT_CODE_W must lie in 1..3");
      end
      if (RESET_CODE < 0 || RESET_CODE > MAX_CODE) begin : g_bad_rc
         $error("RESET_CODE out of range");
      end
   endgenerate

   logic [WAIT_CODE_W-1:0] code_q;
   logic [CW-1:0]          wait_cnt;
   logic [CW-1:0]          wait_need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= WAIT_CODE_W'(RESET_CODE);
      else if (wait_we) code_q <= wait_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wait_cnt <= '0;
      else if (as_n)                     wait_cnt <= '0;
      else if (wait_cnt != CW'(MAX_WAIT)) wait_cnt <= wait_cnt + 1'b1;
   end

   assign wait_need = CW'(1) << code_q;

   assign dtack_n = !(enable && !as_n &&
                      (zero_wait || (spare && (wait_cnt >= wait_need))));

   p_dtack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> dtack_n);

   p_spare_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (spare && !as_n && $past(as_n)) |-> dtack_n);

endmodule

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue #(
   parameter int STRAP_DELAY = 4,
   parameter int BOOT_CYCLES = 4,
   parameter int WAIT_CODE_W = 2,
   parameter int RESET_CODE  = 3,
   parameter int OFFSET_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             strap_i,
   input  logic [2:0]             addr_hi,
   input  logic [OFFSET_W-1:0]    addr_lo,
   input  logic                   as_n,
   input  logic                   rw_n,
   input  logic                   ext_ram_cs_n,
   input  logic                   ext_reg_cs_n,
   input  logic                   wait_we,
   input  logic [WAIT_CODE_W-1:0] wait_code,
   output logic                   straps_valid,
   output logic                   bus_mode,
   output logic                   clk_src_sel,
   output logic                   ram_cs_n,
   output logic                   rom_cs_n,
   output logic                   spare_cs_n,
   output logic                   reg_sel,
   output logic [OFFSET_W-1:0]    reg_offset,
   output logic                   oe_n,
   output logic                   dtack_n,
   output logic                   vpa_n,
   output logic                   romcs_pin_drive,
   output logic                   vpa_pin_drive
);
   import cbg_pkg::*;

   localparam int BW = $clog2(BOOT_CYCLES + 1);

   generate
      if (BOOT_CYCLES < 0) begin : g_bad_boot
         $error("BOOT_CYCLES must not be negative");
      end
   endgenerate

   bus_mode_t   mode;
   region_sel_t sel;
   logic        active, dec, ext, strobe, as_q, boot;
   logic [BW-1:0] boot_left;

   cbg_strap_sampler #(.STRAP_DELAY(STRAP_DELAY)) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .valid   (straps_valid),
      .mode    (mode),
      .clk_src (clk_src_sel)
   );

   assign active = straps_valid && rst_n;
   assign dec    = active && (mode == BUS_DECODED);
   assign ext    = active && (mode == BUS_EXTSEL);
   assign strobe = !as_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_q      <= 1'b1;
         boot_left <= BW'(BOOT_CYCLES);
      end else begin
         as_q <= as_n;
         if (dec && !as_q && as_n && (boot_left != '0))
            boot_left <= boot_left - 1'b1;
      end
   end

   assign boot = (boot_left != '0);

   cbg_region_dec #(.BOOT_REMAP(BOOT_CYCLES > 0)) u_dec (
      .region (addr_hi),
      .boot   (boot),
      .sel    (sel)
   );

   cbg_ack_gen #(.WAIT_CODE_W(WAIT_CODE_W), .RESET_CODE(RESET_CODE)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (dec),
      .as_n      (as_n),
      .zero_wait (sel.zero_wait),
      .spare     (sel.spare),
      .wait_we   (wait_we),
      .wait_code (wait_code),
      .dtack_n   (dtack_n)
   );

   assign ram_cs_n   = !((dec && strobe && sel.ram) || (ext && !ext_ram_cs_n));
   assign rom_cs_n   = !(dec && strobe && sel.rom);
   assign spare_cs_n = !(active && strobe && sel.spare);
   assign reg_sel    = (dec && strobe && sel.regs) ||
                       (ext && strobe && !ext_reg_cs_n);
   assign reg_offset = reg_sel ? addr_lo : '0;
   assign vpa_n      = !(dec && strobe && sel.autovec);
   assign oe_n       = !(active && strobe && rw_n);
   assign bus_mode        = (mode == BUS_EXTSEL);
   assign romcs_pin_drive = dec;
   assign vpa_pin_drive   = dec;

   always_comb begin
      if (!rst_n) assert (ram_cs_n) else $error("p_ram_reset_r10 failed");
   end

   p_vpa_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !vpa_n |-> dtack_n);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (rom_cs_n && spare_cs_n && oe_n && vpa_n && !reg_sel));

   p_no_ram_in_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && boot) |-> ram_cs_n);

   p_ext_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext |-> (rom_cs_n && vpa_n && dtack_n && !romcs_pin_drive));

   p_prestrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !straps_valid |-> (ram_cs_n && rom_cs_n && oe_n && dtack_n && vpa_n));

endmodule

// File: tb/cpu_bus_glue_tb_top.sv
module cpu_bus_glue_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] strap_i;
   logic [2:0] addr_hi;
   logic [7:0] addr_lo;
   logic       as_n, rw_n, ext_ram_cs_n, ext_reg_cs_n, wait_we;
   logic [1:0] wait_code;
   logic       straps_valid, bus_mode, clk_src_sel, ram_cs_n, rom_cs_n;
   logic       spare_cs_n, reg_sel, oe_n, dtack_n, vpa_n;
   logic       romcs_pin_drive, vpa_pin_drive;
   logic [7:0] reg_offset;

   int errors = 0;
   int checks = 0;
   int unsigned seed_v;

   always #2.5 clk = ~clk;

   cpu_bus_glue dut_i (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .addr_hi(addr_hi),
      .addr_lo(addr_lo), .as_n(as_n), .rw_n(rw_n),
      .ext_ram_cs_n(ext_ram_cs_n), .ext_reg_cs_n(ext_reg_cs_n),
      .wait_we(wait_we), .wait_code(wait_code),
      .straps_valid(straps_valid), .bus_mode(bus_mode),
      .clk_src_sel(clk_src_sel), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
      .spare_cs_n(spare_cs_n), .reg_sel(reg_sel), .reg_offset(reg_offset),
      .oe_n(oe_n), .dtack_n(dtack_n), .vpa_n(vpa_n),
      .romcs_pin_drive(romcs_pin_drive), .vpa_pin_drive(vpa_pin_drive)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected selects for the decoded personality (R2, R3, R4, R6)
   function automatic logic e_ram(input logic [2:0] r, input logic boot);
      return (r == 3'b000) && !boot;
   endfunction
   function automatic logic e_rom(input logic [2:0] r, input logic boot);
      return (r == 3'b001) || ((r == 3'b000) && boot);
   endfunction
   function automatic logic e_ack0(input logic [2:0] r);
      return (r != 3'b110) && (r != 3'b111);
   endfunction

   task automatic idle_check();
      chk("R8 rom idle", rom_cs_n, 1);
      chk("R8 oe idle", oe_n, 1);
      chk("R8 dtack idle", dtack_n, 1);
      chk("R8 vpa idle", vpa_n, 1);
      chk("R8 reg idle", reg_sel, 0);
      chk("R8 spare idle", spare_cs_n, 1);
   endtask

   // one decoded-personality access with the strobe low for one edge
   task automatic acc(input logic [2:0] r, input logic rw, input logic [7:0] lo,
                      input logic boot);
      @(negedge clk);
      addr_hi = r; addr_lo = lo; rw_n = rw; as_n = 1'b0;
      #1;
      chk("R2/R6 ram", !ram_cs_n, e_ram(r, boot));
      chk("R2/R6 rom", !rom_cs_n, e_rom(r, boot));
      chk("R2 reg", reg_sel, r == 3'b010);
      chk("R2 offset", reg_offset, (r == 3'b010) ? lo : 8'h00);
      chk("R3 vpa", !vpa_n, r == 3'b111);
      chk("R4 dtack", !dtack_n, e_ack0(r));
      chk("R7 oe", !oe_n, rw);
      @(posedge clk);
      @(negedge clk);
      as_n = 1'b1;
      #1;
      idle_check();
      chk("R8 ram idle", ram_cs_n, 1);
      @(posedge clk);
   endtask

   task automatic spare_acc(input int waits);
      @(negedge clk);
      addr_hi = 3'b110; as_n = 1'b0; rw_n = 1'b0;
      for (int n = 0; n <= waits; n++) begin
         #1;
         chk("R5 spare wait", dtack_n, (n < waits) ? 1 : 0);
         chk("R2 spare cs", spare_cs_n, 0);
         if (n < waits) begin
            @(posedge clk);
            @(negedge clk);
         end
      end
      @(negedge clk);
      as_n = 1'b1;
      @(posedge clk);
   endtask

   task automatic set_code(input logic [1:0] c);
      @(negedge clk);
      wait_we = 1'b1; wait_code = c;
      @(negedge clk);
      wait_we = 1'b0;
   endtask

   task automatic do_reset(input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0; strap_i = s; as_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      seed_v = $urandom(32'h51ED);
      rst_n = 1'b0; strap_i = 2'b10; addr_hi = 3'b000; addr_lo = 8'h00;
      as_n = 1'b0; rw_n = 1'b1; ext_ram_cs_n = 1'b1; ext_reg_cs_n = 1'b1;
      wait_we = 1'b0; wait_code = 2'b00;
      repeat (3) @(negedge clk);
      #1;
      chk("R10 ram in reset", ram_cs_n, 1);
      chk("R1 valid in reset", straps_valid, 0);
      chk("R1 dtack in reset", dtack_n, 1);
      as_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      as_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R1 not yet valid", straps_valid, 0);
      chk("R1 ram pre-capture", ram_cs_n, 1);
      chk("R1 oe pre-capture", oe_n, 1);
      as_n = 1'b1;
      @(posedge clk);
      @(negedge clk); #1;
      chk("R1 valid", straps_valid, 1);
      chk("R1 mode decoded", bus_mode, 0);
      chk("R1 clk src", clk_src_sel, 1);
      chk("R9 drive decoded", romcs_pin_drive, 1);

      // R6: boot window of four strobe cycles
      for (int i = 0; i < 4; i++) acc(3'b000, 1'b1, 8'h00, 1'b1);
      acc(3'b000, 1'b1, 8'h00, 1'b0);
      acc(3'b111, 1'b1, 8'h00, 1'b0);
      acc(3'b010, 1'b0, 8'hA5, 1'b0);

      // constrained random decoded accesses, spare region excluded
      for (int i = 0; i < 40; i++) begin
         logic [2:0] r;
         r = 3'($urandom % 8);
         if (r == 3'b110) r = 3'b011;
         acc(r, 1'($urandom), 8'($urandom), 1'b0);
      end

      // R5 wait states: default code 3, then others
      spare_acc(8);
      set_code(2'd0); spare_acc(1);
      set_code(2'd2); spare_acc(4);
      set_code(2'd1); spare_acc(2);

      // external-select personality
      do_reset(2'b01);
      repeat (5) @(posedge clk);
      @(negedge clk);
      ext_ram_cs_n = 1'b0; #1;
      chk("R1 mode ext", bus_mode, 1);
      chk("R1 clk src 0", clk_src_sel, 0);
      chk("R9 ram follows", ram_cs_n, 0);
      ext_ram_cs_n = 1'b1; #1;
      chk("R9 ram follows hi", ram_cs_n, 1);
      addr_hi = 3'b111; ext_reg_cs_n = 1'b0; addr_lo = 8'h3C; rw_n = 1'b1;
      #1;
      chk("R9 reg idle strobe", reg_sel, 0);
      as_n = 1'b0; #1;
      chk("R9 reg from ext", reg_sel, 1);
      chk("R9 offset", reg_offset, 8'h3C);
      chk("R9 vpa quiet", vpa_n, 1);
      chk("R9 dtack quiet", dtack_n, 1);
      chk("R9 drive off", romcs_pin_drive | vpa_pin_drive, 0);
      chk("R7 oe ext", oe_n, 0);
      addr_hi = 3'b001; #1;
      chk("R9 rom quiet", rom_cs_n, 1);
      addr_hi = 3'b110; #1;
      chk("R9 spare decoded", spare_cs_n, 0);
      @(negedge clk);
      as_n = 1'b1; ext_reg_cs_n = 1'b1; ext_ram_cs_n = 1'b0;
      rst_n = 1'b0; #1;
      chk("R10 ext ram in reset", ram_cs_n, 1);
      repeat (2) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule